// File: doc/BRIEF.md
# Synchronous SRAM Byte-Lane Write Controller

This block turns the write controls of a synchronous SRAM port into a per-lane write-enable vector and applies that vector to a small register-based word array. A 32-bit word is divided into four 8-bit lanes, lane A to lane D. An active-low global write stores the whole word. An active-low byte-write enable, combined with per-lane active-low selects, stores only the chosen lanes. The write happens at the same clock edge that samples the controls, so the port needs no separate write pulse.

A write is accepted only while the chip is selected and the sleep input is low. Raising sleep blocks reads and writes at once, without waiting for a clock. The stored words are kept while sleep is high, and the first rising edge after sleep falls behaves as normal. Reads are combinational from a separate read address.

Top module: `bytewr_ctrl`

## Requirements
- R1: A write takes place only when ce1_n=0, ce2=1 and ce3_n=0. Any other enable combination writes no lane and leaves wstrb at 0.
- R2: While the chip is selected, gw_n=0 writes all four lanes, whatever bwe_n and bsel_n are.
- R3: While the chip is selected with gw_n=1 and bwe_n=0, lane i is written exactly when bsel_n[i]=0. Lane i is data bits 8i+7:8i, and bit 0 is lane A.
- R4: gw_n=1 with bwe_n=1 writes nothing. gw_n=1 with bwe_n=0 and bsel_n=4'hF also writes nothing. In both cases the array keeps its contents.
- R5: The controls, the address and the data are sampled on the rising clock edge. The array is updated at that edge, and after that edge wstrb shows the lanes written at that edge.
- R6: When sleep=0, rdata equals the word stored at raddr, without waiting for a clock.
- R7: While sleep=1, rdata is 0 at once, no edge writes, and wstrb is 0. Stored data is kept. The first edge with sleep=0 writes normally.
- R8: While rst_n=0, wstrb is 0 and every word of the array is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane selects, active low; bit 0 is lane A |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| addr | input | AW | Write word address from the burst generator |
| wdata | input | 32 | Write data |
| sleep | input | 1 | Sleep, active high, asynchronous |
| raddr | input | AW | Read word address |
| wstrb | output | 4 | Lanes written at the last edge |
| rdata | output | 32 | Word read from raddr, 0 while asleep |

## Verification
A wrong lane decode shows on wstrb one edge after the write, and on rdata right after that same edge when raddr points at the written word. A lane that is written when it should not be, or skipped when it should be written, changes the data read back from that word. The bench compares every read with a model of the array, so such an error is reported within the cycle in which it happens. A sleep gate that leaks shows as a nonzero rdata while sleep is high, or as a word that has changed once sleep falls.

// File: rtl/bytewr_ctrl.sv
module bytewr_ctrl #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gw_n,
  input  logic                  bwe_n,
  input  logic [LANES-1:0]      bsel_n,
  input  logic                  ce1_n,
  input  logic                  ce2,
  input  logic                  ce3_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic                  sleep,
  input  logic [AW-1:0]         raddr,
  output logic [LANES-1:0]      wstrb,
  output logic [LANES*LW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic                        chip_sel;
  logic [LANES-1:0]            lane_req;
  logic [LANES-1:0]            lane_we;
  logic [LANES-1:0][LW-1:0]    rd_lane;

  assign chip_sel = !ce1_n && ce2 && !ce3_n && !sleep;
  assign lane_req = !gw_n  ? {LANES{1'b1}} :
                    !bwe_n ? ~bsel_n       : '0;
  assign lane_we  = chip_sel ? lane_req : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wstrb <= '0;
    else        wstrb <= lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) store[w] <= '0;
      end else if (lane_we[g]) begin
        store[addr] <= wdata[g*LW +: LW];
      end

    assign rd_lane[g] = store[raddr];
  end

  assign rdata = sleep ? '0 : rd_lane;
endmodule

// File: rtl/bytewr_ctrl_chk.sv
module bytewr_ctrl_chk #(
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bsel_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             sleep,
  input logic [LANES-1:0] wstrb,
  input logic [DW-1:0]    rdata
);
  logic picked;
  assign picked = !ce1_n && ce2 && !ce3_n;

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(picked)) |-> wstrb == '0); // R1
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(picked) && !$past(sleep) && !$past(gw_n)) |-> wstrb == {LANES{1'b1}}); // R2
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(picked) && !$past(sleep) && $past(gw_n) && !$past(bwe_n))
      |-> wstrb == ~$past(bsel_n)); // R3
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(gw_n) && $past(bwe_n)) |-> wstrb == '0); // R4
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep)) |-> wstrb == '0); // R7
  AST_SLEEP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> rdata == '0); // R7
endmodule

bind bytewr_ctrl bytewr_ctrl_chk #(.LANES(LANES), .DW(LANES*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep),
  .wstrb(wstrb), .rdata(rdata)
);

// File: tb/bytewr_ctrl_bench.sv
module bytewr_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        gw_n = 1, bwe_n = 1, ce1_n = 1, ce2 = 0, ce3_n = 1, sleep = 0;
  logic [3:0]  bsel_n = 4'hF;
  logic [3:0]  addr = 0, raddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  bytewr_ctrl u_bytewr_ctrl (
    .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .addr(addr), .wdata(wdata),
    .sleep(sleep), .raddr(raddr), .wstrb(wstrb), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 16; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    chk(wstrb == 4'h0, "R8 wstrb in reset", {28'd0, wstrb}, 32'd0);
    for (int w = 0; w < 16; w++) begin
      raddr = w[3:0]; #1;
      chk(rdata == 32'd0, "R8 word cleared by reset", rdata, 32'd0);
    end
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 1024; i++) begin
      logic [3:0]  exp_s;
      logic        selx;
      logic [31:0] mask;
      sleep  = i[9];
      ce1_n  = i[6];
      ce2    = i[7];
      ce3_n  = i[8];
      gw_n   = i[5];
      bwe_n  = i[4];
      bsel_n = i[3:0];
      addr   = 4'((i * 7) % 16);
      raddr  = addr;
      wdata  = (i * 32'h9E3779B1) ^ 32'hA5C30F96;
      selx   = !ce1_n && ce2 && !ce3_n && !sleep;
      exp_s  = !selx ? 4'h0 : !gw_n ? 4'hF : !bwe_n ? ~bsel_n : 4'h0;
      #1;
      if (sleep) chk(rdata == 32'd0, "R7 read blocked in sleep", rdata, 32'd0);
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < 4; b++) mask[b*8 +: 8] = {8{exp_s[b]}};
      model[addr] = (model[addr] & ~mask) | (wdata & mask);
      if (!selx && !sleep)
        chk(wstrb == exp_s, "R1 deselected or idle lanes", {28'd0, wstrb}, {28'd0, exp_s});
      else if (sleep)
        chk(wstrb == exp_s, "R7 no strobe in sleep", {28'd0, wstrb}, {28'd0, exp_s});
      else if (!gw_n)
        chk(wstrb == exp_s, "R2 global write all lanes", {28'd0, wstrb}, {28'd0, exp_s});
      else if (!bwe_n && bsel_n != 4'hF)
        chk(wstrb == exp_s, "R3 byte lanes", {28'd0, wstrb}, {28'd0, exp_s});
      else
        chk(wstrb == exp_s, "R4 no enable no write", {28'd0, wstrb}, {28'd0, exp_s});
      sleep = 0; #1;
      chk(rdata == model[addr], "R5 array after edge", rdata, model[addr]);
    end

    gw_n = 1; bwe_n = 1;
    for (int w = 0; w < 16; w++) begin
      raddr = w[3:0]; #1;
      chk(rdata == model[w], "R6 read sweep", rdata, model[w]);
    end

    sleep = 1; ce1_n = 0; ce2 = 1; ce3_n = 0; gw_n = 0; addr = 4'd3; wdata = 32'hDEADBEEF;
    @(posedge clk); @(negedge clk);
    sleep = 0; raddr = 4'd3; #1;
    chk(rdata == model[3], "R7 data kept through sleep", rdata, model[3]);
    @(posedge clk); @(negedge clk);
    model[3] = 32'hDEADBEEF;
    chk(rdata == model[3], "R7 first edge after sleep writes", rdata, model[3]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule